// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Sticky Error Status

This block takes an asynchronous serial line and turns each frame on it into a byte in a holding register. The line is resynchronised and then sampled on a baud-tick strobe that runs at OSR times the bit rate. The receiver waits for a high-to-low transition and confirms the start bit half a bit later. It then samples every following bit at its centre, least significant bit first. A short control register selects the frame shape: 7 or 8 data bits, no/even/odd parity, and one or two stop bits.

A status register carries a holding-full flag and three error flags: overrun, parity and framing. The error flags are sticky. While any of them is set the receiver takes no new frame. Software clears a flag in two steps: it reads status and sees the flag at 1, then writes 0 to that bit. A separate DMA read strobe returns the held byte and clears the full flag in the same cycle. Two level interrupts come from the flags: a receive interrupt from the full flag and an error interrupt from the error flags, each behind its own enable bit. Status bit 7 always shows the synchronised line level, so software can tell a break (line held low) from a single bad stop bit.

Top module: `serial_rx_unit`

## Requirements
- R1: After a falling edge on a line previously seen high, the start bit is confirmed OSR/2 ticks later, and each following bit is sampled OSR ticks after the previous one, LSB first. A clean frame loads the data register (address 2) and sets status bit 0 (full).
- R2: The control register (address 0) holds the frame shape. Bit 1 = 1 selects 7 data bits; bit 7 of the stored byte then reads 0. Bits 3:2 select parity: 00 none, 01 even, 10 odd, 11 none. Bit 4 = 1 selects two stop bits.
- R3: A parity mismatch sets status bit 2. The data register and the full flag are left unchanged.
- R4: A low first stop bit sets status bit 3 and leaves the data and full flag unchanged. A low second stop bit is not checked.
- R5: If the full flag is still 1 when the first stop bit of a new frame is sampled, status bit 1 (overrun) is set. The new frame is dropped and the data register keeps its old byte.
- R6: While any of status bits 1..3 is 1, no frame is taken. Reception resumes once all three are 0.
- R7: A status flag (bits 0..3) is cleared only by a status write (address 1) with that bit at 0, following a status read that saw the flag at 1. A write without such a read, or with the bit at 1, leaves the flag set. Any status write consumes earlier reads.
- R8: A pulse on dma_rd puts the data register on bus_rdata in that cycle and clears the full flag. The error flags are unaffected.
- R9: rx_irq = full AND control bit 5. err_irq = (overrun OR parity OR framing) AND control bit 6.
- R10: Control bit 0 enables reception. With it at 0, no frame is taken, and clearing it mid-frame abandons that frame.
- R11: Status bit 7 shows the synchronised RxD level at all times; status bits 6:4 read 0.
- R12: After reset, control, data and all flags are 0 and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe at OSR times the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flag clearing on status reads) |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; shows the data register while dma_rd is high |
| dma_rd | input | 1 | DMA read of the data register; clears the full flag |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Error interrupt |

## Verification
The bench builds the block with OSR = 8 and DATA_W = 8, and drives a baud tick every fourth clock, so one bit lasts 32 clocks. The short bit time lets many complete frames run in a small cycle budget. These include back-to-back frames for overrun, a held-low break after a framing error, and a reception abandoned half way when the enable is dropped. With a small OSR, a centre-sampling slip of even one tick moves the sample into a neighbouring bit, so the bench's fixed bit patterns expose it.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int BUS_W  = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

    // control bit positions
    localparam int C_EN    = 0;
    localparam int C_SEVEN = 1;
    localparam int C_PAR_L = 2;
    localparam int C_TWOST = 4;
    localparam int C_RXIE  = 5;
    localparam int C_ERRIE = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_RSVD = 2'b11
    } par_mode_e;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;   // line idles high
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rxd_i,
    input  logic              run_i,
    input  logic              seven_i,
    input  par_mode_e         par_i,
    input  logic              two_stop_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              perr_o,
    output logic              ferr_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] MID_C  = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OSR - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] sh;
        logic              pacc;
        logic              perr;
        logic              ferr;
        logic              last;
        logic              done;
    } fr_t;

    fr_t q, d;

    logic [BIT_W-1:0] nbits;
    logic             par_on;
    logic             centre;

    always_comb begin
        nbits  = seven_i ? BIT_W'(DATA_W - 1) : BIT_W'(DATA_W);
        par_on = (par_i == PAR_EVEN) || (par_i == PAR_ODD);
        centre = (q.cnt == LAST_C);

        d      = q;
        d.done = 1'b0;

        if (!run_i) begin
            d.st   = ST_IDLE;
            d.cnt  = '0;
            d.last = 1'b0;           // a high level must be seen first
        end else if (tick_i) begin
            unique case (q.st)
                ST_IDLE: begin
                    d.last = rxd_i;
                    if (q.last && !rxd_i) begin
                        d.st  = ST_START;
                        d.cnt = '0;
                    end
                end
                ST_START: begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == MID_C) begin
                        d.cnt = '0;
                        if (!rxd_i) begin
                            d.st   = ST_DATA;
                            d.bitn = '0;
                            d.pacc = 1'b0;
                            d.perr = 1'b0;
                            d.ferr = 1'b0;
                        end else begin
                            d.st   = ST_IDLE;
                            d.last = rxd_i;
                        end
                    end
                end
                ST_DATA: begin
                    d.cnt = q.cnt + 1'b1;
                    if (centre) begin
                        d.cnt  = '0;
                        d.sh   = {rxd_i, q.sh[DATA_W-1:1]};
                        d.pacc = q.pacc ^ rxd_i;
                        d.bitn = q.bitn + 1'b1;
                        if (q.bitn == nbits - 1'b1)
                            d.st = par_on ? ST_PAR : ST_STOP;
                    end
                end
                ST_PAR: begin
                    d.cnt = q.cnt + 1'b1;
                    if (centre) begin
                        d.cnt  = '0;
                        d.perr = q.pacc ^ rxd_i ^ (par_i == PAR_ODD);
                        d.st   = ST_STOP;
                    end
                end
                ST_STOP: begin
                    d.cnt = q.cnt + 1'b1;
                    if (centre) begin
                        d.cnt  = '0;
                        d.ferr = !rxd_i;
                        d.done = 1'b1;
                        d.last = rxd_i;
                        d.st   = two_stop_i ? ST_STOP2 : ST_IDLE;
                    end
                end
                ST_STOP2: begin
                    d.cnt = q.cnt + 1'b1;
                    if (centre) begin   // sampled but not checked
                        d.cnt  = '0;
                        d.last = rxd_i;
                        d.st   = ST_IDLE;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign data_o = seven_i ? (q.sh >> 1) : q.sh;
    assign perr_o = q.perr;
    assign ferr_o = q.ferr;

    AST_HALT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !done_o);  // R10

endmodule

// File: rtl/srx_regs.sv
module srx_regs
    import srx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    input  logic              dma_rd_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              perr_i,
    input  logic              ferr_i,
    input  logic              rxd_lvl_i,
    output logic              enable_o,
    output logic              seven_o,
    output par_mode_e         par_o,
    output logic              two_stop_o,
    output logic              any_err_o,
    output logic              rx_irq_o,
    output logic              err_irq_o
);
    localparam int NFLAG = 4;   // {ferr, perr, ovr, full}

    typedef struct packed {
        logic [BUS_W-1:0]  ctrl;
        logic [DATA_W-1:0] data;
        logic              full;
        logic              ovr;
        logic              perr;
        logic              ferr;
        logic [NFLAG-1:0]  arm;
    } rg_t;

    rg_t q, d;

    logic             wr_ctrl, wr_stat, rd_stat;
    logic [NFLAG-1:0] flags_q, clr;

    always_comb begin
        flags_q = {q.ferr, q.perr, q.ovr, q.full};
        wr_ctrl = bus_sel_i && bus_wr_i && (bus_addr_i == A_CTRL);
        wr_stat = bus_sel_i && bus_wr_i && (bus_addr_i == A_STAT);
        rd_stat = bus_sel_i && bus_rd_i && (bus_addr_i == A_STAT);

        d     = q;
        d.arm = q.arm & flags_q;
        clr   = '0;

        if (wr_ctrl) d.ctrl = bus_wdata_i;

        if (wr_stat) begin
            clr   = q.arm & ~bus_wdata_i[NFLAG-1:0];
            d.arm = '0;
        end else if (rd_stat) begin
            d.arm = (q.arm | flags_q) & flags_q;
        end

        d.full = q.full & ~clr[0] & ~dma_rd_i;
        d.ovr  = q.ovr  & ~clr[1];
        d.perr = q.perr & ~clr[2];
        d.ferr = q.ferr & ~clr[3];

        if (done_i) begin
            if (q.full) begin
                d.ovr = 1'b1;                  // frame dropped
            end else if (perr_i || ferr_i) begin
                d.perr = q.perr | perr_i;
                d.ferr = q.ferr | ferr_i;
            end else begin
                d.data = data_i;
                d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (dma_rd_i) begin
            bus_rdata_o = BUS_W'(q.data);
        end else begin
            unique case (bus_addr_i)
                A_CTRL:  bus_rdata_o = q.ctrl;
                A_STAT:  bus_rdata_o = {rxd_lvl_i, 3'b000, flags_q};
                A_DATA:  bus_rdata_o = BUS_W'(q.data);
                default: bus_rdata_o = '0;
            endcase
        end
    end

    assign enable_o   = q.ctrl[C_EN];
    assign seven_o    = q.ctrl[C_SEVEN];
    assign par_o      = par_mode_e'(q.ctrl[C_PAR_L+1:C_PAR_L]);
    assign two_stop_o = q.ctrl[C_TWOST];
    assign any_err_o  = q.ovr | q.perr | q.ferr;
    assign rx_irq_o   = q.full & q.ctrl[C_RXIE];
    assign err_irq_o  = any_err_o & q.ctrl[C_ERRIE];

    AST_FULL_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.full) |-> $past(done_i));  // R1
    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovr) |-> $stable(q.data));  // R5
    AST_DMA_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd_i && !done_i) |=> !q.full);  // R8
    AST_PERR_CLEAR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.perr) |-> $past(wr_stat && q.arm[2]));  // R7

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import srx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              rxd,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              dma_rd,
    output logic              rx_irq,
    output logic              err_irq
);
    logic              rxd_s;
    logic              en, seven, two_stop, any_err;
    par_mode_e         par;
    logic              frm_done, frm_perr, frm_ferr;
    logic [DATA_W-1:0] frm_data;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (rxd),
        .sync_o  (rxd_s)
    );

    srx_framer #(.OSR(OSR), .DATA_W(DATA_W)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (baud_tick),
        .rxd_i      (rxd_s),
        .run_i      (en && !any_err),
        .seven_i    (seven),
        .par_i      (par),
        .two_stop_i (two_stop),
        .done_o     (frm_done),
        .data_o     (frm_data),
        .perr_o     (frm_perr),
        .ferr_o     (frm_ferr)
    );

    srx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel_i   (bus_sel),
        .bus_wr_i    (bus_wr),
        .bus_rd_i    (bus_rd),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .dma_rd_i    (dma_rd),
        .done_i      (frm_done),
        .data_i      (frm_data),
        .perr_i      (frm_perr),
        .ferr_i      (frm_ferr),
        .rxd_lvl_i   (rxd_s),
        .enable_o    (en),
        .seven_o     (seven),
        .par_o       (par),
        .two_stop_o  (two_stop),
        .any_err_o   (any_err),
        .rx_irq_o    (rx_irq),
        .err_irq_o   (err_irq)
    );

    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        any_err |=> !frm_done);  // R6

endmodule

// File: tb/serial_rx_unit_bench.sv
module serial_rx_unit_bench;
    localparam int OSR      = 8;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLK  = OSR * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       dma_rd = 1'b0;
    logic       rx_irq, err_irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    serial_rx_unit #(.OSR(OSR), .DATA_W(8)) u_serial_rx_unit (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_rd(dma_rd), .rx_irq(rx_irq), .err_irq(err_irq)
    );

    initial begin : tick_gen
        int tcnt = 0;
        forever begin
            @(negedge clk);
            baud_tick = (tcnt == TICK_DIV - 1);
            tcnt = (tcnt + 1) % TICK_DIV;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic hold_bit(input logic v);
        rxd = v;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    // par: 0 none, 1 even, 2 odd; bad_stop: 0 none, 1 first, 2 second
    task automatic send_frame(input logic [7:0] b, input int nbits, input int par,
                              input int nstop, input bit bad_par, input int bad_stop);
        logic p;
        p = 1'b0;
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < nbits; i++) begin
            hold_bit(b[i]);
            p = p ^ b[i];
        end
        if (par != 0) hold_bit(p ^ (par == 2) ^ bad_par);
        hold_bit(bad_stop == 1 ? 1'b0 : 1'b1);
        if (nstop == 2) hold_bit(bad_stop == 2 ? 1'b0 : 1'b1);
        if (bad_stop == 0) hold_bit(1'b1);
    endtask

    task automatic expect_reg(input string req, input string what,
                              input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] v;
        bus_read(a, v);
        check(req, what, v, exp);
    endtask

    task automatic clear_all();
        logic [7:0] v;
        bus_read(2'd1, v);
        bus_write(2'd1, 8'h00);
    endtask

    task automatic t_reset();
        expect_reg("R12", "ctrl after reset", 2'd0, 8'h00);
        expect_reg("R12", "status after reset (R11 line high)", 2'd1, 8'h80);
        expect_reg("R12", "data after reset", 2'd2, 8'h00);
        check("R12", "irqs after reset", {6'd0, rx_irq, err_irq}, 8'h00);
    endtask

    task automatic t_basic();
        bus_write(2'd0, 8'h61);
        send_frame(8'hA5, 8, 0, 1, 0, 0);
        check("R9", "rx_irq on full", {7'd0, rx_irq}, 8'h01);
        bus_write(2'd1, 8'h00);   // no prior read: must not clear
        expect_reg("R7", "full kept without read", 2'd1, 8'h81);
        bus_write(2'd1, 8'hFF);   // writing 1 keeps it
        expect_reg("R7", "full kept on write 1", 2'd1, 8'h81);
        expect_reg("R1", "8N1 data", 2'd2, 8'hA5);
        clear_all();
        expect_reg("R7", "full cleared after read+write0", 2'd1, 8'h80);
        check("R9", "rx_irq after clear", {7'd0, rx_irq}, 8'h00);
    endtask

    task automatic t_seven();
        bus_write(2'd0, 8'h67);   // enable, 7 bits, even, irqs
        send_frame(8'hB5, 7, 1, 1, 0, 0);
        expect_reg("R2", "7E1 status", 2'd1, 8'h81);
        expect_reg("R2", "7E1 data top bit 0", 2'd2, 8'h35);
        clear_all();
    endtask

    task automatic t_parity();
        bus_write(2'd0, 8'h69);   // 8 bits, odd
        send_frame(8'h3C, 8, 2, 1, 1, 0);
        expect_reg("R3", "parity flag", 2'd1, 8'h84);
        expect_reg("R3", "data unchanged", 2'd2, 8'h35);
        check("R9", "err_irq on parity", {7'd0, err_irq}, 8'h01);
        send_frame(8'h11, 8, 2, 1, 0, 0);
        expect_reg("R6", "frame blocked by error", 2'd1, 8'h84);
        expect_reg("R6", "data kept while blocked", 2'd2, 8'h35);
        clear_all();
        expect_reg("R7", "parity cleared", 2'd1, 8'h80);
        check("R9", "err_irq after clear", {7'd0, err_irq}, 8'h00);
        send_frame(8'h11, 8, 2, 1, 0, 0);
        expect_reg("R6", "resumes after clear", 2'd2, 8'h11);
        clear_all();
    endtask

    task automatic t_framing();
        bus_write(2'd0, 8'h61);
        send_frame(8'h55, 8, 0, 1, 0, 1);   // line stays low: break
        expect_reg("R4", "framing flag, R11 line low", 2'd1, 8'h08);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        expect_reg("R11", "line high again", 2'd1, 8'h88);
        bus_write(2'd1, 8'h00);
        expect_reg("R4", "framing cleared", 2'd1, 8'h80);
        bus_write(2'd0, 8'h71);             // two stop bits
        send_frame(8'h0F, 8, 0, 2, 0, 2);
        rxd = 1'b1;
        repeat (BIT_CLK) @(negedge clk);
        expect_reg("R4", "second stop unchecked", 2'd1, 8'h81);
        expect_reg("R2", "8N2 data", 2'd2, 8'h0F);
        clear_all();
    endtask

    task automatic t_overrun();
        bus_write(2'd0, 8'h61);
        send_frame(8'h12, 8, 0, 1, 0, 0);
        send_frame(8'h34, 8, 0, 1, 0, 0);
        expect_reg("R5", "overrun status", 2'd1, 8'h83);
        expect_reg("R5", "old byte kept", 2'd2, 8'h12);
        bus_write(2'd1, 8'h00);
        expect_reg("R7", "overrun cleared", 2'd1, 8'h80);
    endtask

    task automatic t_dma();
        logic [7:0] v;
        send_frame(8'h9C, 8, 0, 1, 0, 0);
        @(negedge clk);
        dma_rd = 1;
        #1 v = bus_rdata;
        @(negedge clk);
        dma_rd = 0;
        check("R8", "dma read data", v, 8'h9C);
        expect_reg("R8", "dma cleared full", 2'd1, 8'h80);
        check("R8", "rx_irq after dma", {7'd0, rx_irq}, 8'h00);
        send_frame(8'h5A, 8, 0, 1, 0, 0);
        expect_reg("R8", "no overrun after dma", 2'd1, 8'h81);
        @(negedge clk); dma_rd = 1; @(negedge clk); dma_rd = 0;
    endtask

    task automatic t_disable();
        bus_write(2'd0, 8'h60);
        send_frame(8'h77, 8, 0, 1, 0, 0);
        expect_reg("R10", "disabled: no frame", 2'd1, 8'h80);
        expect_reg("R10", "disabled: data kept", 2'd2, 8'h5A);
        bus_write(2'd0, 8'h61);
        repeat (BIT_CLK) @(negedge clk);
        rxd = 1'b0;
        repeat (BIT_CLK) @(negedge clk);
        bus_write(2'd0, 8'h60);             // drop enable mid-frame
        rxd = 1'b1;
        repeat (BIT_CLK * 4) @(negedge clk);
        bus_write(2'd0, 8'h61);
        repeat (BIT_CLK * 8) @(negedge clk);
        expect_reg("R10", "abandoned frame", 2'd1, 8'h80);
        send_frame(8'hC3, 8, 0, 1, 0, 0);
        expect_reg("R10", "receives after re-enable", 2'd2, 8'hC3);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_seven();
        t_parity();
        t_framing();
        t_overrun();
        t_dma();
        t_disable();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule